// File: doc/BRIEF.md
# Not-Recently-Used Victim Selector

This block tracks two flags for each of a fixed number of physical memory frames: a "used" flag that records a frame was referenced, and a "dirty" flag that records it was written. Memory-access logic strobes the used flag on every reference and the dirty flag on every write. When a new page is brought into a frame, a load strobe marks that frame used and clean.

When the paging logic needs a frame to evict, it pulses a request. The block ranks every frame into one of four cost classes built from its two flags. It then answers with the index of a frame taken from the cheapest class that has any members. Within that class the choice is pseudo-random. A free-running linear feedback shift register picks a starting frame, and a circular scan from that frame returns the first member of the class.

A periodic tick input drives an ageing divider. Every `TICK_PERIOD` ticks, all used flags are wiped so that old references stop protecting their frames. The dirty flags are not touched by this wipe. The block does not walk page tables, handle faults or move data. It only names the frame.

Top module: `nru_victim_selector`

## Requirements
- R1: After synchronous reset every frame is unused and clean, `victim_vld` is low, and the ageing divider restarts so the wipe comes on the `TICK_PERIOD`-th tick after reset.
- R2: A cycle with `ref_vld` high sets the used flag of frame `ref_idx`.
- R3: A cycle with `wr_vld` high sets the dirty flag of frame `wr_idx`.
- R4: A cycle with `load_vld` high sets the used flag and clears the dirty flag of frame `load_idx`. If a write strobe hits the same frame in the same cycle, the load wins and the frame ends clean.
- R5: The class of a frame is the 2-bit value {used, dirty}, with used as the upper bit: 0 unused/clean, 1 unused/dirty, 2 used/clean, 3 used/dirty. A lower class is cheaper to evict.
- R6: The returned `victim_idx` always belongs to the lowest class with at least one member. The flags used for the choice are those held just before the request edge.
- R7: The choice within the class is not fixed. When several frames share the lowest class, repeated requests return more than one distinct frame.
- R8: Every `TICK_PERIOD`-th cycle with `tick` high clears the used flags of all frames in that cycle. The dirty flags keep their values, and the divider then reloads.
- R9: If a reference strobe coincides with a wipe, the wipe is applied first and the referenced frame ends with its used flag set.
- R10: `victim_vld` is high for exactly the one cycle after a cycle with `req` high, and is low otherwise. `victim_idx` is meaningful only while `victim_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_vld | input | 1 | Reference strobe |
| ref_idx | input | IDX_W | Frame referenced |
| wr_vld | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Frame written |
| load_vld | input | 1 | Page-load strobe |
| load_idx | input | IDX_W | Frame loaded |
| tick | input | 1 | Ageing tick |
| req | input | 1 | Victim request pulse |
| victim_vld | output | 1 | Victim answer strobe |
| victim_idx | output | IDX_W | Chosen frame |

## Verification
The bench builds the block with eight frames and a wipe every third tick. Eight frames keep the class populations easy to steer one frame at a time, so cases with a single-member lowest class pin down the exact index. The short tick period lets the bench reach a wipe, its reload, and a wipe that coincides with a reference within a few dozen cycles. A burst of requests with all frames in one class shows that the pseudo-random start really moves the choice.

// File: rtl/nru_pkg.sv
package nru_pkg;

    typedef enum logic [1:0] {
        CLS_FRESH       = 2'd0,
        CLS_IDLE_DIRTY  = 2'd1,
        CLS_USED_CLEAN  = 2'd2,
        CLS_USED_DIRTY  = 2'd3
    } nru_class_e;

    localparam int NUM_CLASSES = 4;

    function automatic nru_class_e rank_frame(input logic used, input logic dirty);
        return nru_class_e'({used, dirty});
    endfunction

    typedef struct packed {
        logic vld;
        logic dirty_hit;
    } strobe_hit_t;

endpackage

// File: rtl/nru_tick_divider.sv
module nru_tick_divider #(
    parameter int TICK_PERIOD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic wipe
);
    localparam int CNT_W = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TICK_PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    assign wipe = tick && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RELOAD;
        end else if (tick) begin
            if (cnt_q == '0) begin
                cnt_q <= RELOAD;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/nru_flag_array.sv
module nru_flag_array #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ref_vld,
    input  logic [IDX_W-1:0]      ref_idx,
    input  logic                  wr_vld,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic                  load_vld,
    input  logic [IDX_W-1:0]      load_idx,
    input  logic                  wipe,
    output logic [NUM_FRAMES-1:0] used_q,
    output logic [NUM_FRAMES-1:0] dirty_q
);
    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
        logic ref_hit, wr_hit, load_hit;

        assign ref_hit  = ref_vld  && (ref_idx  == IDX_W'(f));
        assign wr_hit   = wr_vld   && (wr_idx   == IDX_W'(f));
        assign load_hit = load_vld && (load_idx == IDX_W'(f));

        always_ff @(posedge clk) begin
            if (rst) begin
                used_q[f]  <= 1'b0;
                dirty_q[f] <= 1'b0;
            end else begin
                // wipe first, then a fresh reference or load re-marks the frame
                if (wipe) begin
                    used_q[f] <= 1'b0;
                end
                if (ref_hit || load_hit) begin
                    used_q[f] <= 1'b1;
                end
                // a load leaves the frame clean even if written in the same cycle
                if (wr_hit) begin
                    dirty_q[f] <= 1'b1;
                end
                if (load_hit) begin
                    dirty_q[f] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/nru_lfsr.sv
module nru_lfsr #(
    parameter int               LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS  = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED  = 16'h1D2B
) (
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] state_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (state_q[0]) begin
            state_q <= (state_q >> 1) ^ TAPS;
        end else begin
            state_q <= state_q >> 1;
        end
    end
endmodule

// File: rtl/nru_victim_pick.sv
module nru_victim_pick
    import nru_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3
) (
    input  logic [NUM_FRAMES-1:0] used_q,
    input  logic [NUM_FRAMES-1:0] dirty_q,
    input  logic [IDX_W-1:0]      start_idx,
    output logic [IDX_W-1:0]      pick_idx,
    output nru_class_e            pick_class
);
    logic [NUM_FRAMES-1:0] members [NUM_CLASSES];
    logic [NUM_FRAMES-1:0] chosen_set;

    always_comb begin
        for (int c = 0; c < NUM_CLASSES; c++) begin
            members[c] = '0;
        end
        for (int f = 0; f < NUM_FRAMES; f++) begin
            members[rank_frame(used_q[f], dirty_q[f])][f] = 1'b1;
        end
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        pick_class = CLS_USED_DIRTY;
        chosen_set = members[NUM_CLASSES-1];
        for (int c = 0; c < NUM_CLASSES; c++) begin
            if (!found && (|members[c])) begin
                found      = 1'b1;
                pick_class = nru_class_e'(c);
                chosen_set = members[c];
            end
        end
    end

    always_comb begin
        logic hit;
        hit      = 1'b0;
        pick_idx = '0;
        for (int k = 0; k < NUM_FRAMES; k++) begin
            int j;
            j = int'(start_idx) + k;
            if (j >= NUM_FRAMES) begin
                j = j - NUM_FRAMES;
            end
            if (!hit && chosen_set[j]) begin
                hit      = 1'b1;
                pick_idx = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/nru_victim_selector.sv
module nru_victim_selector
    import nru_pkg::*;
#(
    parameter int               NUM_FRAMES  = 8,
    parameter int               TICK_PERIOD = 4,
    parameter int               LFSR_W      = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS  = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED  = 16'h1D2B,
    localparam int              IDX_W       = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_vld,
    input  logic [IDX_W-1:0] ref_idx,
    input  logic             wr_vld,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             load_vld,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             tick,
    input  logic             req,
    output logic             victim_vld,
    output logic [IDX_W-1:0] victim_idx
);
    logic                  wipe;
    logic [NUM_FRAMES-1:0] used_q;
    logic [NUM_FRAMES-1:0] dirty_q;
    logic [LFSR_W-1:0]     lfsr_q;
    logic [LFSR_W-1:0]     start_wide;
    logic [IDX_W-1:0]      start_idx;
    logic [IDX_W-1:0]      pick_idx;
    nru_class_e            pick_class;

    nru_tick_divider #(.TICK_PERIOD(TICK_PERIOD)) div_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .wipe (wipe)
    );

    nru_flag_array #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) flags_i (
        .clk      (clk),
        .rst      (rst),
        .ref_vld  (ref_vld),
        .ref_idx  (ref_idx),
        .wr_vld   (wr_vld),
        .wr_idx   (wr_idx),
        .load_vld (load_vld),
        .load_idx (load_idx),
        .wipe     (wipe),
        .used_q   (used_q),
        .dirty_q  (dirty_q)
    );

    nru_lfsr #(.LFSR_W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) lfsr_i (
        .clk     (clk),
        .rst     (rst),
        .state_q (lfsr_q)
    );

    assign start_wide = lfsr_q % LFSR_W'(NUM_FRAMES);
    assign start_idx  = start_wide[IDX_W-1:0];

    nru_victim_pick #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) pick_i (
        .used_q     (used_q),
        .dirty_q    (dirty_q),
        .start_idx  (start_idx),
        .pick_idx   (pick_idx),
        .pick_class (pick_class)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            victim_vld <= 1'b0;
            victim_idx <= '0;
        end else begin
            victim_vld <= req;
            if (req) begin
                victim_idx <= pick_idx;
            end
        end
    end
endmodule

// File: rtl/nru_victim_chk.sv
module nru_victim_chk #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ref_vld,
    input logic [IDX_W-1:0]      ref_idx,
    input logic                  wr_vld,
    input logic [IDX_W-1:0]      wr_idx,
    input logic                  load_vld,
    input logic [IDX_W-1:0]      load_idx,
    input logic                  req,
    input logic                  victim_vld,
    input logic [IDX_W-1:0]      victim_idx,
    input logic [NUM_FRAMES-1:0] used_q,
    input logic [NUM_FRAMES-1:0] dirty_q
);
    logic [NUM_FRAMES-1:0] used_d;
    logic [NUM_FRAMES-1:0] dirty_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            used_d  <= '0;
            dirty_d <= '0;
        end else begin
            used_d  <= used_q;
            dirty_d <= dirty_q;
        end
    end

    // R10
    answer_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> victim_vld);

    // R10
    no_spurious_answer_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> !victim_vld);

    // R6
    used_victim_only_if_all_used_chk: assert property (@(posedge clk) disable iff (rst)
        (victim_vld && used_d[victim_idx]) |-> (&used_d));

    // R6
    idle_dirty_victim_chk: assert property (@(posedge clk) disable iff (rst)
        (victim_vld && !used_d[victim_idx] && dirty_d[victim_idx]) |-> ((~used_d & ~dirty_d) == '0));

    // R6
    used_dirty_victim_chk: assert property (@(posedge clk) disable iff (rst)
        (victim_vld && used_d[victim_idx] && dirty_d[victim_idx]) |-> ((used_d & ~dirty_d) == '0));

    // R2 R9
    ref_marks_used_chk: assert property (@(posedge clk) disable iff (rst)
        ref_vld |=> used_q[$past(ref_idx)]);

    // R3
    write_marks_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_vld && !(load_vld && load_idx == wr_idx)) |=> dirty_q[$past(wr_idx)]);

    // R4
    load_fresh_chk: assert property (@(posedge clk) disable iff (rst)
        load_vld |=> (used_q[$past(load_idx)] && !dirty_q[$past(load_idx)]));
endmodule

bind nru_victim_selector nru_victim_chk #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ref_vld    (ref_vld),
    .ref_idx    (ref_idx),
    .wr_vld     (wr_vld),
    .wr_idx     (wr_idx),
    .load_vld   (load_vld),
    .load_idx   (load_idx),
    .req        (req),
    .victim_vld (victim_vld),
    .victim_idx (victim_idx),
    .used_q     (used_q),
    .dirty_q    (dirty_q)
);

// File: tb/nru_victim_selector_tb_top.sv
module nru_victim_selector_tb_top;
    localparam int N      = 8;
    localparam int IW     = 3;
    localparam int PERIOD = 3;

    localparam logic [2:0] OP_REF  = 3'd0;
    localparam logic [2:0] OP_WR   = 3'd1;
    localparam logic [2:0] OP_LOAD = 3'd2;
    localparam logic [2:0] OP_TICK = 3'd3;
    localparam logic [2:0] OP_REQ  = 3'd4;
    localparam logic [3:0] ANY     = 4'd8;

    typedef struct packed {
        logic [2:0] op;
        logic [3:0] idx;
        logic [1:0] cls;
        logic [3:0] exi;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VECS [NV] = '{
        '{OP_REQ, 4'd0, 2'd0, ANY},
        '{OP_LOAD, 4'd1, 2'd0, ANY}, '{OP_LOAD, 4'd2, 2'd0, ANY}, '{OP_LOAD, 4'd3, 2'd0, ANY},
        '{OP_LOAD, 4'd4, 2'd0, ANY}, '{OP_LOAD, 4'd5, 2'd0, ANY}, '{OP_LOAD, 4'd6, 2'd0, ANY},
        '{OP_LOAD, 4'd7, 2'd0, ANY},
        '{OP_REQ, 4'd0, 2'd0, 4'd0},
        '{OP_LOAD, 4'd0, 2'd0, ANY},
        '{OP_REQ, 4'd0, 2'd2, ANY},
        '{OP_WR, 4'd3, 2'd0, ANY}, '{OP_WR, 4'd5, 2'd0, ANY},
        '{OP_TICK, 4'd0, 2'd0, ANY}, '{OP_TICK, 4'd0, 2'd0, ANY},
        '{OP_REQ, 4'd0, 2'd2, ANY},
        '{OP_TICK, 4'd0, 2'd0, ANY},
        '{OP_REQ, 4'd0, 2'd0, ANY},
        '{OP_REF, 4'd0, 2'd0, ANY}, '{OP_REF, 4'd1, 2'd0, ANY}, '{OP_REF, 4'd2, 2'd0, ANY},
        '{OP_REF, 4'd4, 2'd0, ANY}, '{OP_REF, 4'd6, 2'd0, ANY}, '{OP_REF, 4'd7, 2'd0, ANY},
        '{OP_REQ, 4'd0, 2'd1, ANY},
        '{OP_REF, 4'd3, 2'd0, ANY},
        '{OP_REQ, 4'd0, 2'd1, 4'd5},
        '{OP_REF, 4'd5, 2'd0, ANY},
        '{OP_REQ, 4'd0, 2'd2, ANY},
        '{OP_WR, 4'd0, 2'd0, ANY}, '{OP_WR, 4'd1, 2'd0, ANY}, '{OP_WR, 4'd2, 2'd0, ANY},
        '{OP_WR, 4'd4, 2'd0, ANY}, '{OP_WR, 4'd6, 2'd0, ANY},
        '{OP_REQ, 4'd0, 2'd2, 4'd7},
        '{OP_WR, 4'd7, 2'd0, ANY},
        '{OP_REQ, 4'd0, 2'd3, ANY},
        '{OP_LOAD, 4'd4, 2'd0, ANY},
        '{OP_REQ, 4'd0, 2'd2, 4'd4}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_vld = 1'b0, wr_vld = 1'b0, load_vld = 1'b0, tick = 1'b0, req = 1'b0;
    logic [IW-1:0] ref_idx = '0, wr_idx = '0, load_idx = '0;
    logic          victim_vld;
    logic [IW-1:0] victim_idx;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [N-1:0] m_used  = '0;
    logic [N-1:0] m_dirty = '0;
    int           m_cnt   = PERIOD - 1;

    always #2 clk = ~clk;

    nru_victim_selector #(.NUM_FRAMES(N), .TICK_PERIOD(PERIOD)) dut_i (
        .clk(clk), .rst(rst),
        .ref_vld(ref_vld), .ref_idx(ref_idx),
        .wr_vld(wr_vld), .wr_idx(wr_idx),
        .load_vld(load_vld), .load_idx(load_idx),
        .tick(tick), .req(req),
        .victim_vld(victim_vld), .victim_idx(victim_idx)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int model_lowest();
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < N; f++) begin
                if (int'({m_used[f], m_dirty[f]}) == c) return c;
            end
        end
        return 3;
    endfunction

    function automatic int model_count(input int c);
        int n = 0;
        for (int f = 0; f < N; f++) begin
            if (int'({m_used[f], m_dirty[f]}) == c) n++;
        end
        return n;
    endfunction

    function automatic int model_only(input int c);
        for (int f = 0; f < N; f++) begin
            if (int'({m_used[f], m_dirty[f]}) == c) return f;
        end
        return 0;
    endfunction

    // model of the ageing divider; returns 1 when this tick wipes (R8)
    function automatic bit model_tick();
        if (m_cnt == 0) begin
            m_cnt = PERIOD - 1;
            return 1'b1;
        end
        m_cnt--;
        return 1'b0;
    endfunction

    task automatic strobe(input logic [2:0] op, input int idx, input bit with_tick);
        bit w;
        @(negedge clk);
        w = with_tick ? model_tick() : 1'b0;
        if (w) m_used = '0;
        case (op)
            OP_REF:  begin ref_vld = 1'b1; ref_idx = IW'(idx); m_used[idx] = 1'b1; end
            OP_WR:   begin wr_vld = 1'b1; wr_idx = IW'(idx); m_dirty[idx] = 1'b1; end
            OP_LOAD: begin load_vld = 1'b1; load_idx = IW'(idx); m_used[idx] = 1'b1; m_dirty[idx] = 1'b0; end
            default: ;
        endcase
        tick = with_tick;
        @(negedge clk);
        ref_vld = 1'b0; wr_vld = 1'b0; load_vld = 1'b0; tick = 1'b0;
    endtask

    // returns the victim index; checks class R6 and timing R10
    task automatic request(input int exp_cls, input int exp_idx, output int got);
        int low, cls;
        low = model_lowest();
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        got = int'(victim_idx);
        check(victim_vld == 1'b1, "R10 valid after req", int'(victim_vld), 1);
        cls = int'({m_used[got], m_dirty[got]});
        check(cls == low, "R6 victim class (R5 {used,dirty})", cls, low);
        if (exp_cls >= 0) check(low == exp_cls, "R6 vector class", low, exp_cls);
        if (exp_idx < N) check(got == exp_idx, "R6 vector index", got, exp_idx);
        else if (model_count(low) == 1) check(got == model_only(low), "R6 single member", got, model_only(low));
        @(negedge clk);
        check(victim_vld == 1'b0, "R10 single-cycle valid", int'(victim_vld), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int got;
        logic [N-1:0] seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(victim_vld == 1'b0, "R1 victim_vld after reset", int'(victim_vld), 0);

        // vector table: R2 R3 R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].op == OP_REQ) begin
                request(int'(VECS[v].cls), int'(VECS[v].exi), got);
            end else if (VECS[v].op == OP_TICK) begin
                strobe(OP_TICK, 0, 1'b1);
            end else begin
                strobe(VECS[v].op, int'(VECS[v].idx), 1'b0);
            end
        end

        // R9: reference coincides with a wipe (third tick after last wipe)
        strobe(OP_TICK, 0, 1'b1);
        strobe(OP_TICK, 0, 1'b1);
        strobe(OP_REF, 6, 1'b1);
        request(0, 4, got);              // R8 frame 4 alone is unused and clean
        strobe(OP_LOAD, 4, 1'b0);
        strobe(OP_WR, 4, 1'b0);
        for (int f = 0; f < N; f++) begin
            if (f != 4 && f != 6) strobe(OP_REF, f, 1'b0);
        end
        request(3, ANY, got);            // R9 frame 6 must still be used

        // R4: load and write to the same frame in one cycle leaves it clean
        @(negedge clk);
        load_vld = 1'b1; load_idx = 3'd2; wr_vld = 1'b1; wr_idx = 3'd2;
        m_used[2] = 1'b1; m_dirty[2] = 1'b0;
        @(negedge clk);
        load_vld = 1'b0; wr_vld = 1'b0;
        request(2, 2, got);

        // R1: reset clears every flag and the divider
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_used = '0; m_dirty = '0; m_cnt = PERIOD - 1;
        check(victim_vld == 1'b0, "R1 victim_vld low after reset", int'(victim_vld), 0);
        request(0, ANY, got);

        // R1 R8: divider restarts; two ticks must not wipe
        strobe(OP_REF, 1, 1'b0);
        strobe(OP_WR, 0, 1'b0);
        for (int f = 2; f < N; f++) strobe(OP_LOAD, f, 1'b0);
        strobe(OP_TICK, 0, 1'b1);
        strobe(OP_TICK, 0, 1'b1);
        request(1, 0, got);              // frame 0 unused/dirty, rest used
        strobe(OP_TICK, 0, 1'b1);        // wipe: frame 0 stays dirty
        request(0, ANY, got);

        // R7: many requests over one populous class reach several frames
        seen = '0;
        for (int r = 0; r < 16; r++) begin
            request(-1, ANY, got);
            seen[got] = 1'b1;
            for (int g = 0; g < (r % 3); g++) @(negedge clk);
        end
        check($countones(seen) >= 2, "R7 distinct victims", $countones(seen), 2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule